// File: doc/BRIEF.md
# Host Controller Status Register

This block holds the status word of a host-side serial bus controller and the small amount of control state that drives it. A run flag, two schedule enables, a frame-list size selector and a doorbell sit in a command word. The status word reports whether the controller has halted and whether each schedule is running, and it passes through an empty-schedule flag. It also carries four latched event flags: async-advance, host system error, frame-list rollover and port change.

Software reaches four 32-bit words through one write port and one combinational read port: command at address 0, status at address 1, interrupt enable at address 2 and frame index at address 3. Hardware events arrive as single-cycle strobes, or as per-port change levels. The interrupt line is the OR of every event flag whose enable bit is set.

Top module: `usbh_status_reg`

## Requirements
- R1: After reset the status word reads 0x00001000 (only bit 12, halted, set), and the command word, the interrupt-enable word and the frame index all read 0.
- R2: Status bit 12 (halted) reads 0 from the edge that sets command bit 0 (run). It returns to 1 exactly two clock edges after the edge that clears run.
- R3: Status bit 15 follows command bit 5 (async schedule enable) and status bit 14 follows command bit 4 (periodic schedule enable). Each changes two clock edges after its enable bit changes, in both directions.
- R4: Status bit 13 reflects the empty-schedule input `reclaim_i` directly.
- R5: Status bits 31:16, 11:6 and 1:0 and command bits 31:7 and 1 always read 0, whatever value was written to them.
- R6: Status bits 5:2 are write-one-to-clear. Writing 0 to one of them leaves it unchanged, and a set event in the same cycle as a clearing write wins.
- R7: Writing 1 to command bit 6 arms the doorbell, which reads back as 1. The next `async_adv_i` strobe sets status bit 5 and clears command bit 6. An `async_adv_i` strobe with the doorbell unarmed sets nothing.
- R8: A `sys_err_i` strobe sets status bit 4 and clears run on the same edge, overriding a software write of run=1 in that cycle.
- R9: The frame index (address 3, 14 bits) increments by one on each `uframe_tick_i` cycle while run is 1 and halted is 0. Otherwise it holds its value.
- R10: Command bits 3:2 select the frame-list size: 0 for 1024 entries (frame index bit 13), 1 for 512 (bit 12), 2 or 3 for 256 (bit 11). Status bit 3 is set on the increment that toggles the selected bit, and on no other increment.
- R11: Status bit 2 is set when a bit of `port_chg_i` goes from 0 to 1 while the same bit of `port_owner_i` is 0. A port with its owner bit at 1 never sets it, and a change level that stays high does not set it again.
- R12: `irq_o` is 1 exactly when some status bit among 5:2 is set and interrupt-enable bit at the same position (address 2, bits 5:2) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write word address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | ADDR_W | Read word address |
| rd_data_o | output | DATA_W | Read data, combinational |
| sys_err_i | input | 1 | Host system access error strobe |
| async_adv_i | input | 1 | Async schedule advanced strobe |
| reclaim_i | input | 1 | Async schedule found empty |
| uframe_tick_i | input | 1 | One microframe elapsed |
| port_chg_i | input | NPORTS | Per-port change levels |
| port_owner_i | input | NPORTS | Per-port handed-off flags |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check that run and halted never read 1 together and that halted rises only after two cycles of run being low. They also check that the reserved status bits stay zero and that an error strobe clears run and latches its flag. Further properties check that the frame index only steps by one and holds while halted, that a clearing write drops the error flag, and that the interrupt line never rises without a source and an enable. The exact two-cycle lag of the schedule bits, the doorbell arming sequence, the rollover position for each list size and the edge-only port detection can only be shown by the bench's scenarios.

// File: rtl/usbh_stat_pkg.sv
package usbh_stat_pkg;

   // word addresses
   localparam int CMD_ADDR  = 0;
   localparam int STS_ADDR  = 1;
   localparam int IE_ADDR   = 2;
   localparam int FIDX_ADDR = 3;

   // command word bits
   localparam int C_RUN     = 0;
   localparam int C_SIZE_LO = 2;
   localparam int C_PEN     = 4;
   localparam int C_AEN     = 5;
   localparam int C_DOOR    = 6;

   // status word bits
   localparam int S_EVT_LO  = 2;
   localparam int N_EVT     = 4;
   localparam int S_HALT    = 12;
   localparam int S_RECL    = 13;
   localparam int S_PSTS    = 14;
   localparam int S_ASTS    = 15;

   // event slot order inside the latched flag vector
   localparam int EV_PORT = 0;
   localparam int EV_ROLL = 1;
   localparam int EV_SERR = 2;
   localparam int EV_AADV = 3;

   typedef enum logic [1:0] {
      FL_1024  = 2'd0,
      FL_512   = 2'd1,
      FL_256   = 2'd2,
      FL_256_B = 2'd3
   } fl_size_e;

   // frame index bit whose toggle marks a wrap of the list
   function automatic int wrap_bit(fl_size_e sz);
      case (sz)
         FL_1024: return 13;
         FL_512:  return 12;
         default: return 11;
      endcase
   endfunction

endpackage

// File: rtl/usbh_lag_line.sv
module usbh_lag_line #(
   parameter int             W       = 1,
   parameter int             DEPTH   = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("usbh_lag_line: DEPTH must be at least 1");
   end
   if (W < 1) begin : g_bad_width
      $error("usbh_lag_line: W must be at least 1");
   end

   logic [W-1:0] stage [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[0] <= RST_VAL;
            else        stage[0] <= d_i;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[g] <= RST_VAL;
            else        stage[g] <= stage[g-1];
         end
      end
   end

   assign q_o = stage[DEPTH-1];

endmodule

// File: rtl/usbh_frame_ctr.sv
module usbh_frame_ctr
   import usbh_stat_pkg::*;
#(
   parameter int FIDX_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv_i,
   input  logic [1:0]        size_i,
   output logic [FIDX_W-1:0] fidx_o,
   output logic              wrap_o
);

   localparam int TOP_WRAP = 13;

   if (FIDX_W <= TOP_WRAP) begin : g_bad_width
      $error("usbh_frame_ctr: FIDX_W must exceed the highest wrap bit");
   end

   logic [FIDX_W-1:0] cnt_q;
   logic [FIDX_W-1:0] cnt_nx;
   int                wb;

   assign cnt_nx = cnt_q + FIDX_W'(1);
   assign wb     = wrap_bit(fl_size_e'(size_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (adv_i) cnt_q <= cnt_nx;
   end

   assign wrap_o = adv_i & (cnt_q[wb] ^ cnt_nx[wb]);
   assign fidx_o = cnt_q;

endmodule

// File: rtl/usbh_port_edge.sv
module usbh_port_edge #(
   parameter int NPORTS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPORTS-1:0] chg_i,
   input  logic [NPORTS-1:0] owner_i,
   output logic              hit_o
);

   if (NPORTS < 1) begin : g_bad_ports
      $error("usbh_port_edge: NPORTS must be at least 1");
   end

   logic [NPORTS-1:0] prev_q;
   logic [NPORTS-1:0] rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= chg_i;
   end

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      assign rise[p] = chg_i[p] & ~prev_q[p] & ~owner_i[p];
   end

   assign hit_o = |rise;

endmodule

// File: rtl/usbh_status_reg.sv
module usbh_status_reg
   import usbh_stat_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 2,
   parameter int NPORTS = 2,
   parameter int FIDX_W = 14,
   parameter int LAG    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              sys_err_i,
   input  logic              async_adv_i,
   input  logic              reclaim_i,
   input  logic              uframe_tick_i,
   input  logic [NPORTS-1:0] port_chg_i,
   input  logic [NPORTS-1:0] port_owner_i,
   output logic              irq_o
);

   localparam int EVT_HI = S_EVT_LO + N_EVT - 1;

   if (DATA_W < 16) begin : g_bad_data
      $error("usbh_status_reg: DATA_W must be at least 16");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("usbh_status_reg: ADDR_W must be at least 2");
   end
   if (FIDX_W > DATA_W) begin : g_bad_fidx
      $error("usbh_status_reg: FIDX_W must fit in a data word");
   end

   // write decode
   logic wr_cmd, wr_sts, wr_ie;
   assign wr_cmd = wr_en_i && (wr_addr_i == ADDR_W'(CMD_ADDR));
   assign wr_sts = wr_en_i && (wr_addr_i == ADDR_W'(STS_ADDR));
   assign wr_ie  = wr_en_i && (wr_addr_i == ADDR_W'(IE_ADDR));

   // command state
   logic       run_q, pen_q, aen_q, door_q;
   logic [1:0] size_q;
   logic       aadv_hit;

   assign aadv_hit = async_adv_i & door_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         pen_q  <= 1'b0;
         aen_q  <= 1'b0;
         size_q <= 2'd0;
      end else begin
         if (wr_cmd) begin
            run_q  <= wr_data_i[C_RUN];
            pen_q  <= wr_data_i[C_PEN];
            aen_q  <= wr_data_i[C_AEN];
            size_q <= wr_data_i[C_SIZE_LO +: 2];
         end
         if (sys_err_i) run_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          door_q <= 1'b0;
      else if (wr_cmd && wr_data_i[C_DOOR]) door_q <= 1'b1;
      else if (aadv_hit)                   door_q <= 1'b0;
   end

   // halted tracking: stop completes LAG edges after run drops
   logic stop_seen;
   logic halted;

   usbh_lag_line #(.W(1), .DEPTH(LAG), .RST_VAL(1'b1)) u_halt_lag (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (~run_q),
      .q_o   (stop_seen)
   );

   assign halted = ~run_q & stop_seen;

   // schedule status lags its enable
   logic [1:0] sched_sts;

   usbh_lag_line #(.W(2), .DEPTH(LAG), .RST_VAL(2'b00)) u_sched_lag (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({aen_q, pen_q}),
      .q_o   (sched_sts)
   );

   // frame index and wrap detection
   logic [FIDX_W-1:0] fidx;
   logic              wrap_ev;

   usbh_frame_ctr #(.FIDX_W(FIDX_W)) u_fctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv_i  (uframe_tick_i & run_q & ~halted),
      .size_i (size_q),
      .fidx_o (fidx),
      .wrap_o (wrap_ev)
   );

   // port change edges
   logic port_ev;

   usbh_port_edge #(.NPORTS(NPORTS)) u_pedge (
      .clk     (clk),
      .rst_n   (rst_n),
      .chg_i   (port_chg_i),
      .owner_i (port_owner_i),
      .hit_o   (port_ev)
   );

   // latched event flags, write-one-to-clear, set wins
   logic [N_EVT-1:0] isr_q, ie_q, set_v, clr_v;

   always_comb begin
      set_v          = '0;
      set_v[EV_PORT] = port_ev;
      set_v[EV_ROLL] = wrap_ev;
      set_v[EV_SERR] = sys_err_i;
      set_v[EV_AADV] = aadv_hit;
      clr_v          = wr_sts ? wr_data_i[EVT_HI:S_EVT_LO] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr_q <= '0;
      end else begin
         for (int b = 0; b < N_EVT; b++) begin
            if (set_v[b])      isr_q[b] <= 1'b1;
            else if (clr_v[b]) isr_q[b] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ie_q <= '0;
      else if (wr_ie) ie_q <= wr_data_i[EVT_HI:S_EVT_LO];
   end

   assign irq_o = |(isr_q & ie_q);

   // read words
   logic [DATA_W-1:0] sts_word, cmd_word, ie_word;

   always_comb begin
      sts_word                    = '0;
      sts_word[EVT_HI:S_EVT_LO]   = isr_q;
      sts_word[S_HALT]            = halted;
      sts_word[S_RECL]            = reclaim_i;
      sts_word[S_PSTS]            = sched_sts[0];
      sts_word[S_ASTS]            = sched_sts[1];

      cmd_word                    = '0;
      cmd_word[C_RUN]             = run_q;
      cmd_word[C_SIZE_LO +: 2]    = size_q;
      cmd_word[C_PEN]             = pen_q;
      cmd_word[C_AEN]             = aen_q;
      cmd_word[C_DOOR]            = door_q;

      ie_word                     = '0;
      ie_word[EVT_HI:S_EVT_LO]    = ie_q;
   end

   always_comb begin
      case (rd_addr_i)
         ADDR_W'(CMD_ADDR):  rd_data_o = cmd_word;
         ADDR_W'(STS_ADDR):  rd_data_o = sts_word;
         ADDR_W'(IE_ADDR):   rd_data_o = ie_word;
         ADDR_W'(FIDX_ADDR): rd_data_o = DATA_W'(fidx);
         default:            rd_data_o = '0;
      endcase
   end

   logic unused_wr_bits;
   assign unused_wr_bits = ^{wr_data_i[DATA_W-1:C_DOOR+1], wr_data_i[1]};

endmodule

// File: rtl/usbh_status_chk.sv
module usbh_status_chk #(
   parameter int DATA_W = 32,
   parameter int FIDX_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run_q,
   input logic              halted,
   input logic              sys_err_i,
   input logic [3:0]        isr_q,
   input logic [3:0]        ie_q,
   input logic              irq_o,
   input logic [DATA_W-1:0] sts_word,
   input logic [FIDX_W-1:0] fidx,
   input logic              wr_sts,
   input logic [DATA_W-1:0] wr_data_i
);

   // R2
   run_not_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> !halted);

   // R2
   halt_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted) |-> (!run_q && $past(!run_q)));

   // R5
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_word[11:6] == 6'd0) && (sts_word[1:0] == 2'd0) && ((sts_word >> 16) == '0));

   // R8
   err_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_err_i |=> (!run_q && isr_q[2]));

   // R6
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sts && wr_data_i[4] && !sys_err_i) |=> !isr_q[2]);

   // R9
   fidx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(fidx));

   // R9
   fidx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fidx) |-> (fidx == $past(fidx) + FIDX_W'(1)));

   // R12
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((isr_q != 4'd0) && (ie_q != 4'd0)));

endmodule

bind usbh_status_reg usbh_status_chk #(.DATA_W(DATA_W), .FIDX_W(FIDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run_q     (run_q),
   .halted    (halted),
   .sys_err_i (sys_err_i),
   .isr_q     (isr_q),
   .ie_q      (ie_q),
   .irq_o     (irq_o),
   .sts_word  (sts_word),
   .fidx      (fidx),
   .wr_sts    (wr_sts),
   .wr_data_i (wr_data_i)
);

// File: tb/usbh_status_reg_test.sv
`timescale 1ns/1ps
module usbh_status_reg_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        sys_err = 1'b0, async_adv = 1'b0, reclaim = 1'b0, utick = 1'b0;
   logic [1:0]  pchg = '0, powner = '0;
   logic        irq;

   int errs = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [31:0] q_exp [$];
   logic [31:0] q_msk [$];
   bit          q_irq [$];
   string       q_tag [$];

   always #5 clk = ~clk;

   usbh_status_reg uut (
      .clk (clk), .rst_n (rst_n),
      .wr_en_i (wr_en), .wr_addr_i (wr_addr), .wr_data_i (wr_data),
      .rd_addr_i (rd_addr), .rd_data_o (rd_data),
      .sys_err_i (sys_err), .async_adv_i (async_adv), .reclaim_i (reclaim),
      .uframe_tick_i (utick), .port_chg_i (pchg), .port_owner_i (powner),
      .irq_o (irq)
   );

   // monitor: one expected item per cycle, sampled 3 ns after the edge
   initial forever begin
      @(posedge clk);
      #3;
      if (q_exp.size() != 0) begin
         logic [31:0] e, m, act;
         bit          is_irq;
         string       t;
         e = q_exp.pop_front();
         m = q_msk.pop_front();
         is_irq = q_irq.pop_front();
         t = q_tag.pop_front();
         act = is_irq ? {31'd0, irq} : rd_data;
         checks++;
         if ((act & m) !== (e & m)) begin
            errs++;
            $display("FAIL %s: got %h expected %h (mask %h)", t, act & m, e & m, m);
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic chk(input logic [1:0] a, input logic [31:0] e, input logic [31:0] m, input string t);
      rd_addr = a;
      q_exp.push_back(e); q_msk.push_back(m); q_irq.push_back(1'b0); q_tag.push_back(t);
      @(negedge clk);
   endtask

   task automatic chk_irq(input bit e, input string t);
      q_exp.push_back({31'd0, e}); q_msk.push_back(32'h1); q_irq.push_back(1'b1); q_tag.push_back(t);
      @(negedge clk);
   endtask

   task automatic ticks(input int n);
      utick = 1'b1;
      repeat (n) @(negedge clk);
      utick = 1'b0;
   endtask

   task automatic pulse_err();
      sys_err = 1'b1; @(negedge clk); sys_err = 1'b0;
   endtask

   task automatic pulse_adv();
      async_adv = 1'b1; @(negedge clk); async_adv = 1'b0;
   endtask

   localparam logic [31:0] ALL = 32'hFFFF_FFFF;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      chk(1, 32'h0000_1000, ALL, "R1 status reset");
      chk(0, 32'h0, ALL, "R1 command reset");
      chk(2, 32'h0, ALL, "R1 irq enable reset");
      chk(3, 32'h0, ALL, "R1 frame index reset");

      // R4 reclaim pass-through
      reclaim = 1'b1;
      chk(1, 32'h0000_3000, ALL, "R4 reclaim high");
      reclaim = 1'b0;

      // R2 run clears halted at once
      wr(0, 32'h1);
      chk(1, 32'h0, ALL, "R2 halted low while running");

      // R3 schedule lag of two edges
      wr(0, 32'h11);
      chk(1, 32'h0000_0000, ALL, "R3 periodic still off one edge later");
      chk(1, 32'h0000_4000, ALL, "R3 periodic on two edges later");
      wr(0, 32'h31);
      chk(1, 32'h0000_4000, ALL, "R3 async still off one edge later");
      chk(1, 32'h0000_C000, ALL, "R3 async on two edges later");

      // R2 / R3 stop: halted and schedule status two edges later
      wr(0, 32'h0);
      chk(1, 32'h0000_C000, ALL, "R2 R3 one edge after stop");
      chk(1, 32'h0000_1000, ALL, "R2 R3 two edges after stop");

      // R7 doorbell
      wr(0, 32'h21);
      pulse_adv();
      chk(1, 32'h0, 32'h20, "R7 advance without doorbell");
      wr(0, 32'h61);
      chk(0, 32'h40, 32'h40, "R7 doorbell armed");
      pulse_adv();
      chk(1, 32'h20, 32'h20, "R7 advance after doorbell");
      chk(0, 32'h0, 32'h40, "R7 doorbell consumed");
      wr(1, 32'h20);
      chk(1, 32'h0, 32'h20, "R6 clear async advance flag");

      // R8 host error
      pulse_err();
      chk(0, 32'h0, 32'h1, "R8 run cleared by error");
      chk(1, 32'h1010, 32'h1010, "R8 error flag and halted");
      wr(1, 32'h0);
      chk(1, 32'h10, 32'h10, "R6 zero write keeps flag");
      sys_err = 1'b1;
      wr(0, 32'h1);
      sys_err = 1'b0;
      chk(0, 32'h0, 32'h1, "R8 error beats run write");
      sys_err = 1'b1;
      wr(1, 32'h10);
      sys_err = 1'b0;
      chk(1, 32'h10, 32'h10, "R6 set wins over clear");

      // R12 interrupt gating
      chk_irq(1'b0, "R12 flag set but not enabled");
      wr(2, 32'h10);
      chk_irq(1'b1, "R12 enabled error flag");
      wr(2, 32'h20);
      chk_irq(1'b0, "R12 other enable only");
      wr(2, 32'h3C);
      chk(2, 32'h3C, ALL, "R12 enable readback");
      wr(1, 32'h10);
      chk(1, 32'h0, 32'h10, "R6 clear error flag");
      chk_irq(1'b0, "R12 no flag left");

      // R11 port change
      powner = 2'b10;
      pchg = 2'b10;
      chk(1, 32'h0, 32'h4, "R11 handed-off port ignored");
      pchg = 2'b11;
      chk(1, 32'h4, 32'h4, "R11 owned port rise");
      chk_irq(1'b1, "R12 port flag enabled");
      wr(1, 32'h4);
      chk(1, 32'h0, 32'h4, "R11 held level does not set again");

      // R9 no counting while halted
      ticks(5);
      chk(3, 32'h0, ALL, "R9 frame index holds while halted");

      // R10 256-entry list: wrap at bit 11
      wr(0, 32'h09);
      ticks(2047);
      chk(3, 32'd2047, ALL, "R9 frame index counts ticks");
      chk(1, 32'h0, 32'h8, "R10 no rollover before bit 11 toggle");
      ticks(1);
      chk(1, 32'h8, 32'h8, "R10 rollover at 256 entries");
      chk(3, 32'd2048, ALL, "R9 frame index after rollover");
      wr(1, 32'h8);

      // R10 512-entry list: wrap at bit 12
      wr(0, 32'h05);
      ticks(2047);
      chk(1, 32'h0, 32'h8, "R10 no rollover before bit 12 toggle");
      ticks(1);
      chk(1, 32'h8, 32'h8, "R10 rollover at 512 entries");
      wr(1, 32'h8);

      // R10 1024-entry list: wrap at bit 13, bit 11 toggle ignored
      wr(0, 32'h01);
      ticks(4095);
      chk(3, 32'd8191, ALL, "R9 frame index before bit 13 toggle");
      chk(1, 32'h0, 32'h8, "R10 bit 11 toggle ignored in 1024 mode");
      ticks(1);
      chk(1, 32'h8, 32'h8, "R10 rollover at 1024 entries");

      // R5 reserved bits
      wr(1, ALL);
      chk(1, 32'h0, 32'hFFFF_0FC3, "R5 status reserved bits");
      wr(0, 32'hFFFF_FF82);
      chk(0, 32'h0, 32'hFFFF_FF82, "R5 command reserved bits");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog (all requirements): got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule